// File: doc/BRIEF.md
# Indirect Register Window for an Interrupt Routing Table

This block is the register front end of an interrupt router. A bus master sees only two word locations. One is an 8-bit selector. The other is a 32-bit data window that reaches whatever register the selector names.

Through the window the master reaches four things:
- a 4-bit identification field;
- a read-only revision word, which also reports how many inputs the router has;
- an arbitration word that always reads zero;
- a table of 64-bit routing entries, one per interrupt input.

Each routing entry is split into two 32-bit halves. The low half sits at an even selector value and the high half at the following odd value.

The block holds the table storage and presents every entry in parallel to a downstream delivery engine. Each time a table half is written, the block raises a one-cycle service request so that the engine re-scans its inputs. The bus uses single-cycle read and write strobes. Read data is combinational for the cycle in which the read strobe is high.

Top module: `irqtab_regwin`

## Requirements
- R1: Only address bits 7:0 are decoded. Offset 0x00 is the selector and offset 0x10 is the data window. Reads of any other offset return zero, and writes to them change nothing.
- R2: A read of offset 0x00 returns, in bits 7:0, the last value written to bits 7:0 at that offset. Bits 31:8 read zero.
- R3: Selector 0x00 is the identification register. A write keeps only bits 27:24 of the data. A read returns that 4-bit value in bits 27:24 and zero in all other bits.
- R4: Selector 0x01 reads 0x11 in bits 7:0 and the input count minus one in bits 23:16, with all other bits zero. Writes to it have no effect.
- R5: Selector 0x02 always reads zero, and writes to it have no effect.
- R6: Selector 0x10+2n maps to bits 31:0 of entry n, and selector 0x11+2n maps to bits 63:32 of entry n. A write changes only the selected half. Entry n is driven on `tbl_entries[64n+63:64n]`.
- R7: Selector values 0x03 to 0x0F, and any value whose entry number is at or beyond the input count, read zero and ignore writes.
- R8: `svc_req` is high for exactly the one cycle after each window write that lands in a table half. Window writes elsewhere do not raise it, and neither do selector writes.
- R9: After reset the selector and the identification field are zero. Every entry is 0x0000_0000_0001_0000, which means only the mask bit (bit 16) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits 7:0 are decoded |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| tbl_entries | output | 64*PINS | All routing entries, entry n in bits 64n+63:64n |
| svc_req | output | 1 | One-cycle service request after a table write |

## Verification
The bench runs with a small input count and walks the selector through all 256 values. At each value it writes a pattern derived from the selector number, reads it back through the window, and checks the service request. This single sweep separates the identification, revision and arbitration registers, the dead gap below 0x10, the valid table halves and the out-of-range tail above the table.

Two companion patterns, one written to the low half and one to the high half, show that a write touches one half only. Address bits set above bit 7 show that those bits are ignored. Writes to unused offsets are followed by reads of both the selector and the window, which shows they change nothing.

// File: rtl/irqtab_pkg.sv
package irqtab_pkg;
   localparam logic [7:0]  OFS_SELECT  = 8'h00;
   localparam logic [7:0]  OFS_WINDOW  = 8'h10;
   localparam logic [7:0]  SEL_IDENT   = 8'h00;
   localparam logic [7:0]  SEL_REVIS   = 8'h01;
   localparam logic [7:0]  SEL_ARBIT   = 8'h02;
   localparam logic [7:0]  SEL_TABLE   = 8'h10;
   localparam logic [7:0]  REV_CODE    = 8'h11;
   localparam int          ENT_W       = 64;
   localparam int          MASK_BIT    = 16;
   localparam logic [63:0] ENT_RESET   = 64'(1) << MASK_BIT;

   typedef struct packed {
      logic hit_select;
      logic hit_window;
      logic is_ident;
      logic is_revis;
      logic tbl_hit;
      logic tbl_high;
   } dec_t;
endpackage

// File: rtl/irqtab_decode.sv
module irqtab_decode
   import irqtab_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int PINS   = 24,
   localparam int IDX_W = (PINS > 1) ? $clog2(PINS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        sel,
   output dec_t              dec,
   output logic [IDX_W-1:0]  tbl_idx
);
   logic [7:0] low_addr;
   logic [7:0] tbl_off;

   assign low_addr = addr[7:0];
   assign tbl_off  = sel - SEL_TABLE;

   always_comb begin
      dec            = '0;
      dec.hit_select = (low_addr == OFS_SELECT);
      dec.hit_window = (low_addr == OFS_WINDOW);
      dec.is_ident   = (sel == SEL_IDENT);
      dec.is_revis   = (sel == SEL_REVIS);
      dec.tbl_hit    = (sel >= SEL_TABLE) && (int'(tbl_off[7:1]) < PINS);
      dec.tbl_high   = sel[0];
   end

   assign tbl_idx = IDX_W'(tbl_off[7:1]);
endmodule

// File: rtl/irqtab_entry.sv
module irqtab_entry
   import irqtab_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [31:0]       wdata,
   output logic [ENT_W-1:0]  q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= ENT_RESET;
      end else begin
         if (wr_lo) q[31:0]  <= wdata;
         if (wr_hi) q[63:32] <= wdata;
      end
   end

   // R6: a write to one half leaves the other half untouched
   p_half_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> $stable(q[63:32]));
   p_half_keep_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo) |=> $stable(q[31:0]));
endmodule

// File: rtl/irqtab_regwin.sv
module irqtab_regwin
   import irqtab_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int PINS   = 24
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   output logic [ENT_W*PINS-1:0] tbl_entries,
   output logic                  svc_req
);
   localparam int IDX_W = (PINS > 1) ? $clog2(PINS) : 1;
   localparam logic [7:0] TOP_PIN = 8'(PINS - 1);

   if (PINS < 1 || PINS > 120) begin : g_bad_pins
      $error("PINS must lie in 1..120 to fit the 8-bit selector");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover at least 8 bits");
   end

   logic [7:0]       sel_q;
   logic [3:0]       ident_q;
   logic             svc_q;
   dec_t             dec;
   logic [IDX_W-1:0] tbl_idx;
   logic             win_wr;
   logic             tbl_wr;
   logic [ENT_W-1:0] ent_q [PINS];
   logic [ENT_W-1:0] ent_sel;

   irqtab_decode #(.ADDR_W(ADDR_W), .PINS(PINS)) u_dec (
      .addr    (bus_addr),
      .sel     (sel_q),
      .dec     (dec),
      .tbl_idx (tbl_idx)
   );

   assign win_wr = bus_wr && dec.hit_window;
   assign tbl_wr = win_wr && dec.tbl_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         ident_q <= '0;
         svc_q   <= 1'b0;
      end else begin
         if (bus_wr && dec.hit_select) sel_q <= bus_wdata[7:0];
         if (win_wr && dec.is_ident)   ident_q <= bus_wdata[27:24];
         svc_q <= tbl_wr;
      end
   end

   for (genvar n = 0; n < PINS; n++) begin : g_ent
      logic hit_n;
      assign hit_n = tbl_wr && (int'(tbl_idx) == n);
      irqtab_entry u_ent (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_lo (hit_n && !dec.tbl_high),
         .wr_hi (hit_n &&  dec.tbl_high),
         .wdata (bus_wdata),
         .q     (ent_q[n])
      );
      assign tbl_entries[ENT_W*n +: ENT_W] = ent_q[n];
   end

   always_comb begin
      ent_sel = '0;
      for (int n = 0; n < PINS; n++)
         if (int'(tbl_idx) == n) ent_sel = ent_q[n];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (dec.hit_select) begin
            bus_rdata = {24'h0, sel_q};
         end else if (dec.hit_window) begin
            if (dec.is_ident)      bus_rdata = {4'h0, ident_q, 24'h0};
            else if (dec.is_revis) bus_rdata = {8'h0, TOP_PIN, 8'h0, REV_CODE};
            else if (dec.tbl_hit)  bus_rdata = dec.tbl_high ? ent_sel[63:32] : ent_sel[31:0];
         end
      end
   end

   assign svc_req = svc_q;

   // R2: the selector holds what was last written to offset 0x00
   p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[7:0] == OFS_SELECT) |=> (sel_q == $past(bus_wdata[7:0])));
   // R8: a service request only follows a bus write
   p_svc_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req |-> $past(bus_wr));
   // R3: identification read exposes only bits 27:24
   p_ident_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[7:0] == OFS_WINDOW && sel_q == SEL_IDENT)
      |-> (bus_rdata[23:0] == '0 && bus_rdata[31:28] == '0));
   // R4: revision word is constant
   p_revis_const_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[7:0] == OFS_WINDOW && sel_q == SEL_REVIS)
      |-> (bus_rdata == {8'h0, TOP_PIN, 8'h0, REV_CODE}));
   // R7: dead selectors read zero
   p_dead_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[7:0] == OFS_WINDOW && sel_q > SEL_ARBIT && !dec.tbl_hit)
      |-> (bus_rdata == '0));
   // R1: undecoded offsets read zero
   p_undecoded_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[7:0] != OFS_SELECT && bus_addr[7:0] != OFS_WINDOW)
      |-> (bus_rdata == '0));
endmodule

// File: tb/irqtab_regwin_test.sv
module irqtab_regwin_test;
   localparam int CLK_PERIOD = 10;
   localparam int PINS   = 4;
   localparam int ADDR_W = 12;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [ADDR_W-1:0]    bus_addr = '0;
   logic                 bus_wr = 1'b0;
   logic                 bus_rd = 1'b0;
   logic [31:0]          bus_wdata = '0;
   logic [31:0]          bus_rdata;
   logic [64*PINS-1:0]   tbl_entries;
   logic                 svc_req;

   int n_chk = 0;
   int n_bad = 0;
   logic [3:0]  m_id;
   logic [31:0] m_lo [PINS];
   logic [31:0] m_hi [PINS];

   irqtab_regwin #(.ADDR_W(ADDR_W), .PINS(PINS)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tbl_entries(tbl_entries), .svc_req(svc_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [ADDR_W-1:0] a, logic [31:0] d, logic exp_svc);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      check("R8 pulse", 64'(svc_req), 64'(exp_svc));
      @(negedge clk);
      check("R8 width", 64'(svc_req), 64'h0);
   endtask

   task automatic bus_read(logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   function automatic logic [31:0] exp_win(int s);
      int e;
      e = (s - 16) / 2;
      if (s == 0) return {4'h0, m_id, 24'h0};
      if (s == 1) return {8'h0, 8'(PINS - 1), 8'h0, 8'h11};
      if (s >= 16 && e < PINS) return (s % 2 == 1) ? m_hi[e] : m_lo[e];
      return 32'h0;
   endfunction

   function automatic logic [31:0] pat(int s, int k);
      return (32'hC3A50000 + 32'(s) * 32'h0101) ^ (32'(k) * 32'h5A5A5A5A);
   endfunction

   task automatic sweep(int k);
      logic [31:0] d;
      for (int s = 0; s < 256; s++) begin
         int e;
         e = (s - 16) / 2;
         bus_write(12'h000, 32'(s), 1'b0);
         bus_read(12'h000, d);
         check("R2 select readback", 64'(d), 64'(s));
         // R1: upper address bits ignored (0x310 aliases the window)
         bus_write(12'h310, pat(s, k), (s >= 16 && e < PINS));
         if (s == 0) m_id = pat(s, k)[27:24];
         if (s >= 16 && e < PINS) begin
            if (s % 2 == 1) m_hi[e] = pat(s, k); else m_lo[e] = pat(s, k);
         end
         bus_read(12'h010, d);
         // R3 R4 R5 R6 R7 by selector class
         check(s == 0 ? "R3 ident" : s == 1 ? "R4 revision" : s == 2 ? "R5 arbitration" :
               (s >= 16 && e < PINS) ? "R6 table half" : "R7 dead index",
               64'(d), 64'(exp_win(s)));
      end
      for (int n = 0; n < PINS; n++)
         check("R6 table port", tbl_entries[64*n +: 64], {m_hi[n], m_lo[n]});
   endtask

   initial begin
      logic [31:0] d;
      m_id = '0;
      for (int n = 0; n < PINS; n++) begin
         m_lo[n] = 32'h0001_0000;
         m_hi[n] = 32'h0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      bus_read(12'h000, d);
      check("R9 select reset", 64'(d), 64'h0);
      bus_read(12'h010, d);
      check("R9 ident reset", 64'(d), 64'h0);
      for (int n = 0; n < PINS; n++)
         check("R9 entry reset", tbl_entries[64*n +: 64], 64'h0000_0000_0001_0000);
      check("R9 svc idle", 64'(svc_req), 64'h0);

      sweep(0);
      sweep(1);

      // R1: unused offsets ignore writes and read zero
      bus_write(12'h000, 32'h12, 1'b0);
      bus_write(12'h004, 32'hFFFF_FFFF, 1'b0);
      bus_write(12'h020, 32'hFFFF_FFFF, 1'b0);
      bus_write(12'h0FF, 32'hFFFF_FFFF, 1'b0);
      bus_read(12'h000, d);
      check("R1 select unchanged", 64'(d), 64'h12);
      bus_read(12'h010, d);
      check("R1 window unchanged", 64'(d), 64'(exp_win(18)));
      bus_read(12'h020, d);
      check("R1 unused reads zero", 64'(d), 64'h0);
      bus_read(12'h108, d);
      check("R1 unused reads zero", 64'(d), 64'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule